// File: doc/BRIEF.md
# MDIO Management Master with Command Gateway

This block runs Clause 22 management transactions on an MDC/MDIO pair on behalf of software. Software composes one 32-bit command word (PHY address, register address, opcode, write data) and writes it to a gateway register. The block then serialises one complete management frame. When the frame ends it clears the busy flag in the same register, and for a read it places the 16 received bits in the low half of that register.

A completed transaction leaves the block locked. No further command starts until software writes an all-zero word to the gateway. That same zero write also cancels a frame still in flight. A second register sets the MDC half-period and the core-clock offsets at which MDIO is driven and sampled. It also stores pad settings that the block only keeps for readback.

The register port is a plain single-cycle write strobe with a combinational read mux. It accepts every write in the cycle it is presented and never applies back-pressure, so there is no valid/ready stream at the edge of this block.

Top module: `mdio_gateway_master`

## Requirements
- R1: Offset 0x0 holds the command word: data [15:0], register address [20:16], PHY address [25:21], opcode [27:26], start bit [28], busy [30]. A nonzero write to offset 0x0 starts a frame when the block is neither busy nor locked. The word must have busy=1, start bit=1 and opcode 1 (write) or 2 (read). The word is stored, and bit 30 reads back as 1 until the frame ends.
- R2: Each frame is, in order: 32 ones, then 0 and 1, then the opcode on the wire (write 0,1 and read 1,0), then PHY address [25:21] MSB first, then register address [20:16] MSB first, then the turnaround, then 16 data bits MSB first. For a write the turnaround is 1,0 and the data is command bits [15:0]. Every bit is stable on mdio_o when MDC rises.
- R3: In a read, mdio_oe is low from the first turnaround bit to the end of the frame. mdio_i is captured for the 16 data bits, MSB first. After completion, gateway bits [15:0] hold the received value.
- R4: MDC starts low. Each half-period lasts P+1 core cycles, where P is configuration bits [15:8], so one MDC period is 2*(P+1) core cycles.
- R5: mdio_o takes a new bit on the core edge that comes O+1 edges after the edge that lowers MDC, where O is configuration bits [31:24]. mdio_i is captured on the core edge I+1 edges after the edge that raises MDC, where I is bits [23:16]. Both offsets are limited to P.
- R6: At the MDC falling edge that ends the 64th bit, busy (bit 30) clears and the lock is set. A command written while busy or locked is ignored and leaves the gateway unchanged.
- R7: Writing 0x00000000 to offset 0x0 clears the gateway, releases the lock and cancels any frame in progress. By the next cycle MDC is low and mdio_oe is low, and a later command runs normally.
- R8: Whenever no frame is in progress, MDC is low and mdio_oe is low.
- R9: Offset 0x4 is a 32-bit read/write configuration register with reset value 0x0D061315 (mode [1:0]=1, 3.3 V select [2]=1, full drive [4]=1, P=0x13, I=6, O=13). Writes to it while busy are ignored.
- R10: A nonzero gateway write with busy=0, start bit=0, or opcode 0 or 3 is ignored. The gateway stays unchanged and no frame starts.
- R11: Addresses other than 0x0 and 0x4 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_en | input | 1 | Register write strobe, one write per cycle |
| csr_addr | input | ADDR_W | Byte address of the register (0x0 gateway, 0x4 configuration) |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Combinational read data for csr_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (pad drives mdio_o when high) |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
On every cycle, the bound checker enforces the busy and lock rules. A frame starts only when the block is free. Completion happens only inside a frame and always leaves the block locked and not busy. A zero write always releases it. MDC and the output enable stay quiet while idle. Only the bench scenarios can show that the serialised bit order and turnaround are right. The same holds for the half-period length and the output-change offset at each configuration, the received read data landing in the gateway, and the rejection of malformed, locked and busy-time writes.

// File: rtl/mdio_gw_pkg.sv
package mdio_gw_pkg;
  localparam int WORD_W      = 32;
  localparam int BUSY_BIT    = 30;
  localparam int ST1_BIT     = 28;
  localparam int OP_LSB      = 26;
  localparam int PHY_LSB     = 21;
  localparam int REG_LSB     = 16;
  localparam int ADR_W       = 5;
  localparam int DATA_W      = 16;
  localparam int CFG_FIELD_W = 8;
  localparam int CFG_PER_LSB = 8;
  localparam int CFG_IN_LSB  = 16;
  localparam int CFG_OUT_LSB = 24;

  localparam logic [1:0] OP_WR = 2'b01;
  localparam logic [1:0] OP_RD = 2'b10;

  localparam int PRE_LEN   = 32;
  localparam int BODY_LEN  = 32;
  localparam int FRAME_LEN = PRE_LEN + BODY_LEN;
  localparam int TA_IDX    = PRE_LEN + 14;
  localparam int DATA_IDX  = PRE_LEN + 16;

  typedef struct packed {
    logic              rd;
    logic [ADR_W-1:0]  phy;
    logic [ADR_W-1:0]  regad;
    logic [DATA_W-1:0] wdata;
  } mdio_cmd_t;

  function automatic logic [BODY_LEN-1:0] body_word(mdio_cmd_t c);
    return {2'b01, (c.rd ? OP_RD : OP_WR), c.phy, c.regad,
            (c.rd ? 2'b11 : 2'b10), c.wdata};
  endfunction
endpackage

// File: rtl/mdio_gw_regs.sv
module mdio_gw_regs
  import mdio_gw_pkg::*;
#(
  parameter int          ADDR_W    = 3,
  parameter int          GW_ADDR   = 0,
  parameter int          CFG_ADDR  = 4,
  parameter logic [31:0] CFG_RESET = 32'h0D06_1315
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [WORD_W-1:0]      wdata,
  output logic [WORD_W-1:0]      rdata,
  input  logic                   done,
  input  logic [DATA_W-1:0]      rx_data,
  output logic                   busy,
  output logic                   lock,
  output logic                   start,
  output logic                   abort,
  output mdio_cmd_t              cmd,
  output logic [CFG_FIELD_W-1:0] period,
  output logic [CFG_FIELD_W-1:0] in_off,
  output logic [CFG_FIELD_W-1:0] out_off
);
  logic [WORD_W-1:0] gw_q, cfg_q;
  logic busy_q, lock_q;
  logic sel_gw, sel_cfg, wr_gw, well_formed;
  logic [1:0] wop;

  assign sel_gw  = (addr == ADDR_W'(GW_ADDR));
  assign sel_cfg = (addr == ADDR_W'(CFG_ADDR));
  assign wr_gw   = wr_en && sel_gw;
  assign wop     = wdata[OP_LSB +: 2];

  assign well_formed = wdata[BUSY_BIT] && wdata[ST1_BIT] &&
                       ((wop == OP_WR) || (wop == OP_RD));
  assign abort = wr_gw && (wdata == '0);
  assign start = wr_gw && !abort && well_formed && !busy_q && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gw_q   <= '0;
      busy_q <= 1'b0;
      lock_q <= 1'b0;
    end else if (abort) begin
      gw_q   <= '0;
      busy_q <= 1'b0;
      lock_q <= 1'b0;
    end else if (start) begin
      gw_q   <= wdata;
      busy_q <= 1'b1;
    end else if (done) begin
      busy_q         <= 1'b0;
      lock_q         <= 1'b1;
      gw_q[BUSY_BIT] <= 1'b0;
      if (cmd.rd) gw_q[DATA_W-1:0] <= rx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cfg_q <= CFG_RESET;
    else if (wr_en && sel_cfg && !busy_q) cfg_q <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (sel_gw)       rdata = gw_q;
    else if (sel_cfg) rdata = cfg_q;
  end

  assign busy      = busy_q;
  assign lock      = lock_q;
  assign cmd.rd    = (gw_q[OP_LSB +: 2] == OP_RD);
  assign cmd.phy   = gw_q[PHY_LSB +: ADR_W];
  assign cmd.regad = gw_q[REG_LSB +: ADR_W];
  assign cmd.wdata = gw_q[DATA_W-1:0];
  assign period    = cfg_q[CFG_PER_LSB +: CFG_FIELD_W];
  assign in_off    = cfg_q[CFG_IN_LSB +: CFG_FIELD_W];
  assign out_off   = cfg_q[CFG_OUT_LSB +: CFG_FIELD_W];
endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             abort,
  input  logic [DIV_W-1:0] period,
  input  logic [DIV_W-1:0] in_off,
  input  logic [DIV_W-1:0] out_off,
  output logic             mdc,
  output logic             drive_evt,
  output logic             samp_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] ph;
  logic [DIV_W-1:0] in_eff, out_eff;
  logic mdc_q;

  assign in_eff  = (in_off  > period) ? period : in_off;
  assign out_eff = (out_off > period) ? period : out_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= '0;
      mdc_q <= 1'b0;
    end else if (!run || abort) begin
      ph    <= '0;
      mdc_q <= 1'b0;
    end else if (ph == period) begin
      ph    <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign mdc       = mdc_q;
  assign drive_evt = run && !mdc_q && (ph == out_eff);
  assign samp_evt  = run &&  mdc_q && (ph == in_eff);
  assign fall_evt  = run &&  mdc_q && (ph == period);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_gw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  mdio_cmd_t         cmd,
  input  logic              drive_evt,
  input  logic              samp_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rx_data
);
  localparam int CNT_W = $clog2(FRAME_LEN);

  logic             active;
  logic [CNT_W-1:0] bitn;
  logic [DATA_W-1:0] rx_q, rx_shift;
  logic [BODY_LEN-1:0] body;
  logic [4:0] bidx;
  logic cur_bit, last, in_ta_or_data, in_data, take_in;

  assign body          = body_word(cmd);
  assign bidx          = 5'(FRAME_LEN - 1 - int'(bitn));
  assign cur_bit       = (int'(bitn) < PRE_LEN) ? 1'b1 : body[bidx];
  assign last          = (bitn == CNT_W'(FRAME_LEN - 1));
  assign in_ta_or_data = (bitn >= CNT_W'(TA_IDX));
  assign in_data       = (bitn >= CNT_W'(DATA_IDX));
  assign take_in       = active && samp_evt && cmd.rd && in_data;
  assign rx_shift      = {rx_q[DATA_W-2:0], mdio_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      bitn    <= '0;
      rx_q    <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (abort) begin
      active  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      bitn    <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (active) begin
      if (drive_evt) begin
        mdio_o  <= cur_bit;
        mdio_oe <= !(cmd.rd && in_ta_or_data);
      end
      if (take_in) rx_q <= rx_shift;
      if (fall_evt) begin
        if (last) begin
          active  <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          bitn <= bitn + 1'b1;
        end
      end
    end
  end

  assign done    = active && fall_evt && last;
  assign rx_data = take_in ? rx_shift : rx_q;
endmodule

// File: rtl/mdio_gateway_master.sv
module mdio_gateway_master
  import mdio_gw_pkg::*;
#(
  parameter int          ADDR_W    = 3,
  parameter logic [31:0] CFG_RESET = 32'h0D06_1315
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr_en,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic busy_w, lock_w, start_w, abort_w, done_w;
  logic drive_evt_w, samp_evt_w, fall_evt_w;
  mdio_cmd_t cmd_w;
  logic [DATA_W-1:0] rx_w;
  logic [CFG_FIELD_W-1:0] period_w, in_off_w, out_off_w;

  mdio_gw_regs #(
    .ADDR_W(ADDR_W), .GW_ADDR(0), .CFG_ADDR(4), .CFG_RESET(CFG_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(csr_wr_en), .addr(csr_addr),
    .wdata(csr_wdata), .rdata(csr_rdata), .done(done_w), .rx_data(rx_w),
    .busy(busy_w), .lock(lock_w), .start(start_w), .abort(abort_w),
    .cmd(cmd_w), .period(period_w), .in_off(in_off_w), .out_off(out_off_w)
  );

  mdio_mdc_gen #(.DIV_W(CFG_FIELD_W)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .abort(abort_w),
    .period(period_w), .in_off(in_off_w), .out_off(out_off_w),
    .mdc(mdc), .drive_evt(drive_evt_w), .samp_evt(samp_evt_w),
    .fall_evt(fall_evt_w)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_w), .abort(abort_w),
    .cmd(cmd_w), .drive_evt(drive_evt_w), .samp_evt(samp_evt_w),
    .fall_evt(fall_evt_w), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .done(done_w), .rx_data(rx_w)
  );
endmodule

// File: rtl/mdio_gw_checker.sv
module mdio_gw_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic lock,
  input logic start,
  input logic abort,
  input logic done,
  input logic mdc,
  input logic mdio_oe
);
  p_start_when_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!busy && !lock));

  p_done_inside_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_lock_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !abort) |=> (lock && !busy));

  p_busy_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && !abort) |=> busy);

  p_zero_write_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !lock && !mdc && !mdio_oe));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));
endmodule

bind mdio_gateway_master mdio_gw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_w), .lock(lock_w),
  .start(start_w), .abort(abort_w), .done(done_w),
  .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/mdio_gateway_master_test.sv
module mdio_gateway_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr_en = 1'b0;
  logic [2:0]  csr_addr = 3'h0;
  logic [31:0] csr_wdata = 32'h0;
  logic [31:0] csr_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #4 clk = ~clk;

  mdio_gateway_master uut (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0;
  int fails = 0;
  logic [1:0]  exp_q[$];
  logic [63:0] phy_vec = '1;
  int rise_cnt = 0;
  int cur_p = 19;
  int cur_out = 13;
  bit quiet = 1'b1;
  bit seen_fall = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr_en = 1'b0; csr_wdata = 32'h0;
  endtask

  task automatic csr_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  function automatic logic [31:0] mk_cmd(bit rd, logic [4:0] phy,
                                         logic [4:0] rg, logic [15:0] d);
    return {1'b0, 1'b1, 1'b0, 1'b1, (rd ? 2'b10 : 2'b01), phy, rg, d};
  endfunction

  // driver: pushes the expected wire bits, arms the PHY model, issues
  task automatic run_cmd(bit rd, logic [4:0] phy, logic [4:0] rg,
                         logic [15:0] d, logic [15:0] phy_data);
    logic [31:0] body;
    body = {2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
    exp_q.delete();
    for (int i = 0; i < 32; i++) exp_q.push_back(2'b11);
    for (int i = 0; i < 32; i++)
      exp_q.push_back({!(rd && i >= 14), body[31-i]});
    phy_vec   = {{47{1'b1}}, 1'b0, phy_data};
    rise_cnt  = 0;
    seen_fall = 1'b0;
    mdio_i    = 1'b1;
    quiet     = 1'b0;
    csr_write(3'h0, mk_cmd(rd, phy, rg, d));
  endtask

  task automatic wait_idle(string req);
    logic [31:0] v;
    int n;
    n = 0;
    v = 32'hFFFF_FFFF;
    while (v[30] && n < 6000) begin
      csr_read(3'h0, v);
      n++;
    end
    check({req, " completion within limit"}, {31'h0, v[30]}, 32'h0);
  endtask

  // monitor: pops one expected bit per MDC rising edge, times MDC and MDIO
  logic prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0;
  int len = 0;
  logic [1:0] item;
  always @(posedge clk) begin
    #2;
    if (rst_n && !quiet) begin
      if (mdc !== prev_mdc) begin
        if (seen_fall) check("R4 MDC half-period length", len, cur_p + 1);
        if (mdc) begin
          if (exp_q.size() == 0) check("R2 MDC edge with no frame bit due", 1, 0);
          else begin
            item = exp_q.pop_front();
            check("R3 output enable at MDC rise", {31'h0, mdio_oe}, {31'h0, item[1]});
            if (item[1]) check("R2 frame bit at MDC rise", {31'h0, mdio_o}, {31'h0, item[0]});
          end
          rise_cnt++;
        end else begin
          seen_fall = 1'b1;
          if (rise_cnt < 64) mdio_i = phy_vec[63-rise_cnt];
        end
        len = 1;
      end else begin
        len++;
      end
      if (!mdc && seen_fall && mdio_oe && prev_oe && (mdio_o !== prev_o))
        check("R5 output change offset after MDC fall", len, cur_out + 2);
    end
    prev_mdc = mdc;
    prev_o   = mdio_o;
    prev_oe  = mdio_oe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, c;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R8 MDC low after reset", {31'h0, mdc}, 32'h0);
    check("R8 output enable low after reset", {31'h0, mdio_oe}, 32'h0);
    csr_read(3'h0, v); check("R1 gateway reset value", v, 32'h0);
    csr_read(3'h4, v); check("R9 config reset value", v, 32'h0D06_1315);

    // configuration P=2, I=1, O=1
    csr_write(3'h4, 32'h0101_0215);
    cur_p = 2; cur_out = 1;
    csr_read(3'h4, v); check("R9 config readback", v, 32'h0101_0215);

    // write frame
    c = mk_cmd(1'b0, 5'h15, 5'h0A, 16'hBEEF);
    run_cmd(1'b0, 5'h15, 5'h0A, 16'hBEEF, 16'h0);
    csr_read(3'h0, v); check("R1 command stored with busy set", v, c);
    csr_write(3'h4, 32'hFFFF_FFFF);
    csr_read(3'h4, v); check("R9 config write ignored while busy", v, 32'h0101_0215);
    csr_write(3'h0, mk_cmd(1'b1, 5'h01, 5'h02, 16'h0));
    csr_read(3'h0, v); check("R6 command ignored while busy", v, c);
    wait_idle("R6");
    csr_read(3'h0, v); check("R6 busy cleared after frame", v, c & ~32'h4000_0000);
    check("R2 all frame bits seen", exp_q.size(), 0);

    // locked: new command ignored
    quiet = 1'b1;
    csr_write(3'h0, mk_cmd(1'b1, 5'h02, 5'h03, 16'h0));
    repeat (12) @(negedge clk);
    check("R6 no MDC activity while locked", {31'h0, mdc}, 32'h0);
    csr_read(3'h0, v); check("R6 gateway unchanged while locked", v, c & ~32'h4000_0000);
    csr_write(3'h0, 32'h0);
    csr_read(3'h0, v); check("R7 zero write clears gateway", v, 32'h0);

    // read frame
    c = mk_cmd(1'b1, 5'h03, 5'h1F, 16'h0);
    run_cmd(1'b1, 5'h03, 5'h1F, 16'h0, 16'hA5C3);
    wait_idle("R3");
    csr_read(3'h0, v);
    check("R3 read data returned in gateway", v, (c & ~32'h4000_0000) | 32'h0000_A5C3);
    check("R3 all read frame bits seen", exp_q.size(), 0);
    quiet = 1'b1;
    csr_write(3'h0, 32'h0);

    // second configuration P=3, I=3, O=2
    csr_write(3'h4, 32'h0203_0315);
    cur_p = 3; cur_out = 2;
    run_cmd(1'b0, 5'h1F, 5'h00, 16'h0001, 16'h0);
    wait_idle("R4");
    check("R4 frame bits at slower MDC", exp_q.size(), 0);
    quiet = 1'b1;
    csr_write(3'h0, 32'h0);
    run_cmd(1'b1, 5'h0C, 5'h11, 16'h0, 16'h5A0F);
    wait_idle("R5");
    csr_read(3'h0, v);
    check("R5 read data sampled at input offset", v[15:0], 32'h5A0F);
    quiet = 1'b1;
    csr_write(3'h0, 32'h0);

    // abort mid-frame
    run_cmd(1'b0, 5'h05, 5'h06, 16'h1234, 16'h0);
    repeat (150) @(negedge clk);
    quiet = 1'b1;
    csr_write(3'h0, 32'h0);
    exp_q.delete();
    check("R7 MDC low after abort", {31'h0, mdc}, 32'h0);
    check("R7 output enable low after abort", {31'h0, mdio_oe}, 32'h0);
    csr_read(3'h0, v); check("R7 gateway cleared by abort", v, 32'h0);
    repeat (40) @(negedge clk);
    check("R8 MDC stays low when idle", {31'h0, mdc}, 32'h0);
    run_cmd(1'b0, 5'h09, 5'h0E, 16'hC001, 16'h0);
    wait_idle("R7");
    check("R7 frame after abort complete", exp_q.size(), 0);
    quiet = 1'b1;
    csr_write(3'h0, 32'h0);

    // malformed commands
    csr_write(3'h0, mk_cmd(1'b0, 5'h01, 5'h01, 16'h1) & ~32'h4000_0000);
    csr_read(3'h0, v); check("R10 busy bit clear ignored", v, 32'h0);
    csr_write(3'h0, mk_cmd(1'b0, 5'h01, 5'h01, 16'h1) & ~32'h1000_0000);
    csr_read(3'h0, v); check("R10 start bit clear ignored", v, 32'h0);
    csr_write(3'h0, mk_cmd(1'b0, 5'h01, 5'h01, 16'h1) | 32'h0C00_0000);
    csr_read(3'h0, v); check("R10 opcode 3 ignored", v, 32'h0);
    csr_write(3'h0, mk_cmd(1'b0, 5'h01, 5'h01, 16'h1) & ~32'h0C00_0000);
    csr_read(3'h0, v); check("R10 opcode 0 ignored", v, 32'h0);
    repeat (10) @(negedge clk);
    check("R10 no MDC activity after malformed", {31'h0, mdc}, 32'h0);

    // unmapped addresses
    csr_write(3'h2, 32'hDEAD_BEEF);
    csr_read(3'h2, v); check("R11 unmapped reads zero", v, 32'h0);
    csr_write(3'h6, 32'h1234_5678);
    csr_read(3'h6, v); check("R11 unmapped reads zero", v, 32'h0);
    csr_read(3'h4, v); check("R11 config untouched by unmapped write", v, 32'h0203_0315);
    csr_read(3'h0, v); check("R11 gateway untouched by unmapped write", v, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule